// File: doc/BRIEF.md
# Configurable NAND Cell Array

The block is a rectangular grid of tiny logic cells. Each cell holds a two-bit code that picks one of four functions: tie low, pass the neighbour to its left, pass the neighbour diagonally up-left, or NAND those two neighbours. Signals move strictly from column to column. Column 0 reads a primary input vector, and the last column's outputs are registered as the result vector. Any code matrix therefore describes a loop-free combinational netlist, and the array evaluates that netlist on every clock.

A configuration is written one row per cycle into a staging copy. It reaches the evaluating copy only when a commit strobe is given. A new matrix can be assembled while the old circuit keeps running, and the swap happens at one clock edge. How the matrix is chosen lies outside the block. Grid height and width are parameters.

Top module: `nand_cell_array`

## Requirements
- R1: `out_vec` is registered. The value present after a rising edge is the array function of the `in_vec` sampled at that edge, under the configuration that was active before that edge.
- R2: A cell with code 0 drives 0, whatever its inputs.
- R3: A cell with code 1 drives its first input, which is the output of the same row in the previous column.
- R4: A cell with code 2 drives its second input, which is the output of the row above (row r-1) in the previous column. Row 0 takes its second input from the last row.
- R5: A cell with code 3 drives the NAND of its first and second inputs.
- R6: When `cfg_load` is high, `cfg_word` is written into staging row `cfg_row`, with column c's code in bits [2c+1:2c]. Staged data has no effect on `out_vec` until a commit.
- R7: When `cfg_commit` is high, the whole staging matrix becomes the active matrix at that edge. A row loaded in the same cycle as a commit goes to staging only, and the committed matrix holds that row's previous contents.
- R8: A synchronous reset clears the staging matrix, the active matrix and `out_vec`. `out_vec` stays 0 until the first commit.
- R9: For column 0, `in_vec[r]` is the first input of row r, and `in_vec[r-1]` (wrapping to the top bit for row 0) is the second input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Write `cfg_word` into staging row `cfg_row` |
| cfg_row | input | $clog2(ROWS) | Staging row address |
| cfg_word | input | 2*COLS | Row of codes, column c in bits [2c+1:2c] |
| cfg_commit | input | 1 | Copy staging matrix to active matrix |
| in_vec | input | ROWS | Primary inputs, one per row, into column 0 |
| out_vec | output | ROWS | Registered outputs of the last column |

## Verification
The array is driven with uniform matrices: all ground, all straight, all slanted and all NAND. Each one isolates a single cell function. The slanted matrix runs on a grid whose width is not a multiple of its height, so a wrong wrap direction produces a visibly rotated output rather than an identity. Deterministic pseudo-random matrices with varied inputs then exercise mixed codes and the field layout of the row word. Two further cases separate staging from activation: loads without a commit, and a load coinciding with a commit.

// File: rtl/nca_pkg.sv
package nca_pkg;

  typedef enum logic [1:0] {
    CELL_GND   = 2'd0,
    CELL_PASS  = 2'd1,
    CELL_SLANT = 2'd2,
    CELL_NAND  = 2'd3
  } cell_op_e;

  // Function of one cell given its two neighbour inputs.
  function automatic logic cell_eval(cell_op_e op, logic a, logic b);
    case (op)
      CELL_GND:   return 1'b0;
      CELL_PASS:  return a;
      CELL_SLANT: return b;
      default:    return ~(a & b);
    endcase
  endfunction

  // Row feeding the second input of row r (row above, wrapping).
  function automatic int up_row(int r, int rows);
    return (r == 0) ? rows - 1 : r - 1;
  endfunction

endpackage

// File: rtl/nca_cfg_store.sv
module nca_cfg_store #(
  parameter int ROWS = 64,
  parameter int COLS = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                load_en,
  input  logic [$clog2(ROWS)-1:0]             load_row,
  input  logic [2*COLS-1:0]                   load_word,
  input  logic                                commit,
  output logic [COLS-1:0][2*ROWS-1:0]         col_codes
);

  // Staging is row-major (as written); active is column-major (as used).
  logic [ROWS-1:0][2*COLS-1:0] stage_q;
  logic [COLS-1:0][2*ROWS-1:0] act_q;
  logic                        row_ok;

  assign row_ok = (32'(load_row) < ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (load_en && row_ok) stage_q[load_row] <= load_word;
      if (commit) begin
        for (int c = 0; c < COLS; c++)
          for (int r = 0; r < ROWS; r++)
            act_q[c][2*r +: 2] <= stage_q[r][2*c +: 2];
      end
    end
  end

  assign col_codes = act_q;

  // R6: staged writes never reach the evaluating matrix without a commit
  p_stage_isolated_r6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_q));

endmodule

// File: rtl/nca_cell_column.sv
module nca_cell_column
  import nca_pkg::*;
#(
  parameter int ROWS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*ROWS-1:0]   codes,
  input  logic [ROWS-1:0]     a_in,
  output logic [ROWS-1:0]     y
);

  logic [ROWS-1:0] b_vec;
  logic [ROWS-1:0] gnd_mask, pass_mask, slant_mask, nand_mask;

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      y[r] = cell_eval(cell_op_e'(codes[2*r +: 2]), a_in[r], a_in[up_row(r, ROWS)]);
  end

  // Named views of the column used by the assertions below.
  assign b_vec = {a_in[ROWS-2:0], a_in[ROWS-1]};

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      gnd_mask[r]   = (codes[2*r +: 2] == CELL_GND);
      pass_mask[r]  = (codes[2*r +: 2] == CELL_PASS);
      slant_mask[r] = (codes[2*r +: 2] == CELL_SLANT);
      nand_mask[r]  = (codes[2*r +: 2] == CELL_NAND);
    end
  end

  p_ground_cells_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (y & gnd_mask) == '0);

  p_straight_cells_pass_r3: assert property (@(posedge clk) disable iff (rst)
    ((y ^ a_in) & pass_mask) == '0);

  p_slant_cells_pass_r4: assert property (@(posedge clk) disable iff (rst)
    ((y ^ b_vec) & slant_mask) == '0);

  p_nand_cells_r5: assert property (@(posedge clk) disable iff (rst)
    ((y ^ ~(a_in & b_vec)) & nand_mask) == '0);

endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
  parameter int ROWS = 64,
  parameter int COLS = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_load,
  input  logic [$clog2(ROWS)-1:0]   cfg_row,
  input  logic [2*COLS-1:0]         cfg_word,
  input  logic                      cfg_commit,
  input  logic [ROWS-1:0]           in_vec,
  output logic [ROWS-1:0]           out_vec
);

  logic [COLS-1:0][2*ROWS-1:0] col_codes;
  logic [COLS:0][ROWS-1:0]     col_sig;
  logic [ROWS-1:0]             out_q;
  logic                        live_q;

  nca_cfg_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_en   (cfg_load),
    .load_row  (cfg_row),
    .load_word (cfg_word),
    .commit    (cfg_commit),
    .col_codes (col_codes)
  );

  // R9: primary inputs feed column 0 as its previous-column signals
  assign col_sig[0] = in_vec;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    nca_cell_column #(.ROWS(ROWS)) u_col (
      .clk   (clk),
      .rst   (rst),
      .codes (col_codes[c]),
      .a_in  (col_sig[c]),
      .y     (col_sig[c+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      live_q <= 1'b0;
    end else begin
      out_q <= col_sig[COLS];
      if (cfg_commit) live_q <= 1'b1;
    end
  end

  assign out_vec = out_q;

  // R8: nothing but zeros leaves the array before the first commit
  p_idle_until_commit_r8: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> out_q == '0);

endmodule

// File: tb/test_nand_cell_array.sv
module test_nand_cell_array;

  localparam int ROWS = 4;
  localparam int COLS = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_load;
  logic [1:0]        cfg_row;
  logic [2*COLS-1:0] cfg_word;
  logic              cfg_commit;
  logic [ROWS-1:0]   in_vec;
  logic [ROWS-1:0]   out_vec;

  always #10 clk = ~clk;  // 50 MHz

  nand_cell_array #(.ROWS(ROWS), .COLS(COLS)) i_nand_cell_array (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_row(cfg_row),
    .cfg_word(cfg_word), .cfg_commit(cfg_commit), .in_vec(in_vec),
    .out_vec(out_vec)
  );

  typedef struct { logic [ROWS-1:0] exp; string tag; } item_t;
  item_t q[$];

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int stage_m [ROWS][COLS];
  int act_m   [ROWS][COLS];

  // Independent model: walk the grid column by column with integers.
  function automatic logic [ROWS-1:0] model(logic [ROWS-1:0] x);
    int cur [ROWS];
    int nxt [ROWS];
    logic [ROWS-1:0] res;
    for (int r = 0; r < ROWS; r++) cur[r] = int'(x[r]);
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        int first, second;
        first  = cur[r];
        second = cur[(r + ROWS - 1) % ROWS];
        if (act_m[r][c] == 0)      nxt[r] = 0;
        else if (act_m[r][c] == 1) nxt[r] = first;
        else if (act_m[r][c] == 2) nxt[r] = second;
        else                       nxt[r] = (first == 1 && second == 1) ? 0 : 1;
      end
      for (int r = 0; r < ROWS; r++) cur[r] = nxt[r];
    end
    for (int r = 0; r < ROWS; r++) res[r] = (cur[r] != 0);
    return res;
  endfunction

  task automatic idle();
    @(negedge clk);
    cfg_load = 0; cfg_commit = 0;
  endtask

  task automatic load(int r, logic [2*COLS-1:0] w, bit with_commit);
    @(negedge clk);
    cfg_load = 1; cfg_row = 2'(r); cfg_word = w; cfg_commit = with_commit;
    if (with_commit) act_m = stage_m;
    for (int c = 0; c < COLS; c++) stage_m[r][c] = int'(w[2*c +: 2]);
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_load = 0; cfg_commit = 1;
    act_m = stage_m;
  endtask

  task automatic fill(logic [1:0] code);
    for (int r = 0; r < ROWS; r++) load(r, {COLS{code}}, 0);
  endtask

  // Driver: apply one input vector and push its expected result.
  task automatic drive(logic [ROWS-1:0] x, string tag);
    item_t it;
    @(negedge clk);
    cfg_load = 0; cfg_commit = 0; in_vec = x;
    it.exp = model(x); it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: the edge after each push registers that vector's result.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compared++;
      if (out_vec !== it.exp) begin
        mismatched++;
        $display("FAIL %s: out_vec=%b expected=%b", it.tag, out_vec, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1; cfg_load = 0; cfg_row = 0; cfg_word = 0; cfg_commit = 0; in_vec = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin stage_m[r][c] = 0; act_m[r][c] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    drive(4'hF, "R8 reset state");
    drive(4'h5, "R8 reset state");

    fill(2'd1);                       // staged only
    drive(4'hF, "R6 staged not active");
    drive(4'hA, "R6 staged not active");

    commit();
    for (int v = 0; v < 16; v += 3) drive(4'(v), "R3 R9 straight wires");
    drive(4'h9, "R1 back-to-back");
    drive(4'h6, "R1 back-to-back");

    fill(2'd2); commit();
    drive(4'h1, "R4 slanted wrap");
    drive(4'h2, "R4 slanted wrap");
    drive(4'h8, "R4 slanted wrap");
    drive(4'hC, "R9 R4 column0 second input");

    fill(2'd3); commit();
    drive(4'h0, "R5 nand all");
    drive(4'hF, "R5 nand all");
    drive(4'h5, "R5 nand all");

    fill(2'd0); commit();
    drive(4'hF, "R2 ground all");

    fill(2'd1);
    load(0, {COLS{2'd3}}, 1);         // load and commit in one cycle
    drive(4'h1, "R7 commit takes old row");
    drive(4'hE, "R7 commit takes old row");
    commit();
    drive(4'h1, "R7 row applied after commit");
    drive(4'hE, "R7 row applied after commit");

    lfsr = 16'hACE1;
    for (int k = 0; k < 6; k++) begin
      for (int r = 0; r < ROWS; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        load(r, lfsr[2*COLS-1:0], 0);
      end
      commit();
      for (int v = 0; v < 4; v++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drive(lfsr[ROWS-1:0], "R1 R6 mixed codes");
      end
    end

    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule